// File: doc/BRIEF.md
# Rank-Modulation Cell Array with Push-to-Top Writes

This block models a group of multi-level storage cells whose information content is the order of their levels, not the level values themselves. Each cell holds a discrete level between 0 and `Q_LEVELS-1`. The stored symbol is the permutation obtained by listing the cell indices from the highest level down to the lowest. The permutation is driven on an output at all times.

There is one write primitive. A push command names one cell and raises it to one level above the level that is currently the largest, which makes that cell the new top of the order. A push whose target cell is already at the top leaves everything as it is. When no level is left above the current maximum, the push is refused and an overflow flag pulses. An erase command puts every level back to the starting ladder, and that ladder encodes the identity permutation. Choosing which permutation carries which user data, and in what sequence to push, is the job of logic outside this block.

Top module: `rm_push_array`

## Requirements
- R1: During reset and in the first cycle after it, cell i holds level `N_CELLS-1-i`, `perm_o` is the identity (slot k holds index k), and `overflow_o` is low.
- R2: An accepted push of cell p raises the level of p to the prior maximum level plus one and leaves every other cell unchanged. The new levels and permutation are visible right after the clock edge that sampled the push. A push is accepted when p is not at the maximum and the maximum is below `Q_LEVELS-1`.
- R3: A push of the cell that already holds the maximum level changes no level and does not raise `overflow_o`.
- R4: A push of a cell that is not at the maximum, made while the maximum already equals `Q_LEVELS-1`, changes no level. It drives `overflow_o` high for the cycle that follows the sampling edge, and `overflow_o` is low in every cycle that does not follow such a push.
- R5: `perm_o` packs `N_CELLS` fields of `$clog2(N_CELLS)` bits each. Field k sits at bits `[k*IDX_W +: IDX_W]` and holds the index of the cell with the k-th highest level, with field 0 the highest. Equal levels rank the lower index first.
- R6: Erase returns the levels to the R1 ladder at the next edge. It takes priority over a push in the same cycle, and it never raises `overflow_o`.
- R7: `levels_o` packs the cell levels, with cell i at bits `[i*LVL_W +: LVL_W]`. No level ever exceeds `Q_LEVELS-1`, and `perm_o` always lists each cell index exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid_i | input | 1 | Push command for one cycle |
| push_idx_i | input | IDX_W | Cell to move to the top |
| erase_i | input | 1 | Return all levels to the starting ladder |
| levels_o | output | N_CELLS*LVL_W | Current level of every cell |
| perm_o | output | N_CELLS*IDX_W | Cell indices ordered from highest to lowest level |
| overflow_o | output | 1 | One-cycle pulse for a refused push |

## Verification
The assertions assume that `Q_LEVELS` is at least `N_CELLS`, so the erase ladder fits, and that `push_valid_i` and `erase_i` are low while reset is held. Under those assumptions the levels stay distinct, and the tie rule never decides an order. The stimulus holds reset with both commands low and changes inputs only on falling edges. It starts every push sequence from an erase, so every level the sweep reaches is one that pushes can legally produce.

// File: rtl/rm_pkg.sv
package rm_pkg;

  // Ordering rule between two cells: higher level wins, lower index breaks ties.
  function automatic logic outranks(input int unsigned lvl_a, input int unsigned idx_a,
                                    input int unsigned lvl_b, input int unsigned idx_b);
    return (lvl_a > lvl_b) || ((lvl_a == lvl_b) && (idx_a < idx_b));
  endfunction

  // Level a cell takes after erase: a descending ladder giving the identity order.
  function automatic int unsigned erased_level(input int unsigned idx, input int unsigned n);
    return n - 1 - idx;
  endfunction

endpackage

// File: rtl/rm_max_tree.sv
module rm_max_tree #(
  parameter int N_CELLS = 4,
  parameter int LVL_W   = 3,
  parameter int IDX_W   = 2
) (
  input  logic [N_CELLS*LVL_W-1:0] levels_i,
  output logic [LVL_W-1:0]         max_lvl_o,
  output logic [IDX_W-1:0]         top_idx_o
);
  always_comb begin
    max_lvl_o = levels_i[0 +: LVL_W];
    top_idx_o = '0;
    for (int i = 1; i < N_CELLS; i++) begin
      if (levels_i[i*LVL_W +: LVL_W] > max_lvl_o) begin
        max_lvl_o = levels_i[i*LVL_W +: LVL_W];
        top_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rm_level_store.sv
module rm_level_store #(
  parameter int N_CELLS  = 4,
  parameter int Q_LEVELS = 5,
  parameter int LVL_W    = 3,
  parameter int IDX_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_valid_i,
  input  logic [IDX_W-1:0]         push_idx_i,
  input  logic                     erase_i,
  input  logic [LVL_W-1:0]         max_lvl_i,
  input  logic [IDX_W-1:0]         top_idx_i,
  output logic [N_CELLS*LVL_W-1:0] levels_o,
  output logic                     overflow_o
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(Q_LEVELS - 1);

  logic [LVL_W-1:0]         lvl_q [N_CELLS];
  logic [N_CELLS*LVL_W-1:0] erased_flat;
  logic [N_CELLS-1:0]       sel_oh;
  logic [LVL_W-1:0]         sel_lvl;
  logic [LVL_W-1:0]         next_top_lvl;
  logic idx_ok, push_live, push_hit_top, push_full, push_accept, push_reject;
  logic ovf_q;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    localparam logic [LVL_W-1:0] ERASED = LVL_W'(rm_pkg::erased_level(g, N_CELLS));
    assign sel_oh[g]                     = (push_idx_i == IDX_W'(g));
    assign erased_flat[g*LVL_W +: LVL_W] = ERASED;
    assign levels_o[g*LVL_W +: LVL_W]    = lvl_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n || erase_i) lvl_q[g] <= ERASED;
      else if (push_accept && sel_oh[g]) lvl_q[g] <= next_top_lvl;
    end
  end

  always_comb begin
    sel_lvl = '0;
    for (int i = 0; i < N_CELLS; i++)
      if (sel_oh[i]) sel_lvl = lvl_q[i];
  end

  assign idx_ok       = |sel_oh;
  assign push_live    = push_valid_i && !erase_i && idx_ok;
  assign push_hit_top = (sel_lvl == max_lvl_i);
  assign push_full    = (max_lvl_i >= TOP_LVL);
  assign push_accept  = push_live && !push_hit_top && !push_full;
  assign push_reject  = push_live && !push_hit_top && push_full;
  assign next_top_lvl = max_lvl_i + LVL_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= push_reject;
  end
  assign overflow_o = ovf_q;

  // R2
  accept_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_accept |=> (top_idx_i == $past(push_idx_i)) && (max_lvl_i == $past(max_lvl_i) + LVL_W'(1)));
  // R3
  top_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_live && push_hit_top) |=> $stable(levels_o) && !overflow_o);
  // R4
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> $stable(levels_o) && $past(push_valid_i) && !$past(erase_i));
  // R6
  erase_ladder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> (levels_o == erased_flat) && !overflow_o);
endmodule

// File: rtl/rm_rank_perm.sv
module rm_rank_perm #(
  parameter int N_CELLS = 4,
  parameter int LVL_W   = 3,
  parameter int IDX_W   = 2
) (
  input  logic [N_CELLS*LVL_W-1:0] levels_i,
  output logic [N_CELLS*IDX_W-1:0] perm_o
);
  logic [IDX_W-1:0] rank [N_CELLS];

  for (genvar c = 0; c < N_CELLS; c++) begin : g_rank
    always_comb begin
      rank[c] = '0;
      for (int j = 0; j < N_CELLS; j++)
        if (rm_pkg::outranks(32'(levels_i[j*LVL_W +: LVL_W]), j,
                             32'(levels_i[c*LVL_W +: LVL_W]), c))
          rank[c] = rank[c] + IDX_W'(1);
    end
  end

  always_comb begin
    perm_o = '0;
    for (int k = 0; k < N_CELLS; k++)
      for (int i = 0; i < N_CELLS; i++)
        if (rank[i] == IDX_W'(k)) perm_o[k*IDX_W +: IDX_W] = IDX_W'(i);
  end
endmodule

// File: rtl/rm_push_array.sv
module rm_push_array #(
  parameter int N_CELLS  = 4,
  parameter int Q_LEVELS = 5,
  localparam int IDX_W   = (N_CELLS > 1) ? $clog2(N_CELLS) : 1,
  localparam int LVL_W   = (Q_LEVELS > 1) ? $clog2(Q_LEVELS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_valid_i,
  input  logic [IDX_W-1:0]         push_idx_i,
  input  logic                     erase_i,
  output logic [N_CELLS*LVL_W-1:0] levels_o,
  output logic [N_CELLS*IDX_W-1:0] perm_o,
  output logic                     overflow_o
);
  logic [LVL_W-1:0]   max_lvl;
  logic [IDX_W-1:0]   top_idx;
  logic [N_CELLS-1:0] seen;

  rm_max_tree #(.N_CELLS(N_CELLS), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_max (
    .levels_i(levels_o), .max_lvl_o(max_lvl), .top_idx_o(top_idx));

  rm_level_store #(.N_CELLS(N_CELLS), .Q_LEVELS(Q_LEVELS), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push_valid_i(push_valid_i), .push_idx_i(push_idx_i),
    .erase_i(erase_i), .max_lvl_i(max_lvl), .top_idx_i(top_idx),
    .levels_o(levels_o), .overflow_o(overflow_o));

  rm_rank_perm #(.N_CELLS(N_CELLS), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_rank (
    .levels_i(levels_o), .perm_o(perm_o));

  always_comb begin
    seen = '0;
    for (int k = 0; k < N_CELLS; k++)
      for (int i = 0; i < N_CELLS; i++)
        if (perm_o[k*IDX_W +: IDX_W] == IDX_W'(i)) seen[i] = 1'b1;
  end

  // R7
  perm_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == N_CELLS);
  // R7
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    max_lvl <= LVL_W'(Q_LEVELS - 1));
  // R5
  perm_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_o[0 +: IDX_W] == top_idx);

  for (genvar k = 0; k + 1 < N_CELLS; k++) begin : g_order
    logic [IDX_W-1:0] hi_idx, lo_idx;
    assign hi_idx = perm_o[k*IDX_W +: IDX_W];
    assign lo_idx = perm_o[(k+1)*IDX_W +: IDX_W];
    // R5
    perm_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      levels_o[hi_idx*LVL_W +: LVL_W] >= levels_o[lo_idx*LVL_W +: LVL_W]);
  end
endmodule

// File: tb/test_rm_push_array.sv
module test_rm_push_array;
  localparam int N  = 4;
  localparam int Q  = 5;
  localparam int IW = 2;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [IW-1:0] push_idx = '0;
  logic erase = 1'b0;
  logic [N*LW-1:0] levels;
  logic [N*IW-1:0] perm;
  logic overflow;

  int checks = 0;
  int errors = 0;
  int exp_lvl [N];
  int exp_ovf = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rm_push_array #(.N_CELLS(N), .Q_LEVELS(Q)) i_rm_push_array (
    .clk(clk), .rst_n(rst_n), .push_valid_i(push_valid), .push_idx_i(push_idx),
    .erase_i(erase), .levels_o(levels), .perm_o(perm), .overflow_o(overflow));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_erase();
    for (int i = 0; i < N; i++) exp_lvl[i] = N - 1 - i;
    exp_ovf = 0;
  endtask

  task automatic model_push(input int p);
    int mx = 0;
    for (int i = 0; i < N; i++) if (exp_lvl[i] > mx) mx = exp_lvl[i];
    exp_ovf = 0;
    if (exp_lvl[p] == mx) return;
    if (mx + 1 > Q - 1) exp_ovf = 1;
    else exp_lvl[p] = mx + 1;
  endtask

  task automatic check_all(input string lvl_tag);
    int slot = 0;
    for (int i = 0; i < N; i++) begin
      check(lvl_tag, int'(levels[i*LW +: LW]), exp_lvl[i]);
      if (int'(levels[i*LW +: LW]) > Q - 1) check("R7 range", int'(levels[i*LW +: LW]), Q - 1);
    end
    // R5: expected order by scanning levels from the top down
    for (int v = Q - 1; v >= 0; v--)
      for (int i = 0; i < N; i++)
        if (exp_lvl[i] == v) begin
          check("R5 perm", int'(perm[slot*IW +: IW]), i);
          slot++;
        end
    check("R4 overflow", int'(overflow), exp_ovf);
  endtask

  task automatic step(input bit do_push, input int idx, input bit do_erase, input string tag);
    push_valid = do_push;
    push_idx   = IW'(idx);
    erase      = do_erase;
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0;
    erase      = 1'b0;
    if (do_erase) model_erase();
    else if (do_push) model_push(idx);
    else exp_ovf = 0;
    check_all(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset ladder and identity permutation
    model_erase();
    check_all("R1 reset");
    for (int k = 0; k < N; k++) check("R1 identity", int'(perm[k*IW +: IW]), k);

    // Exhaustive sweep over all push sequences of length 3 from the erased state
    for (int s = 0; s < N*N*N; s++) begin
      step(1'b0, 0, 1'b1, "R6 erase");
      for (int d = 0; d < 3; d++) begin
        int p = (s >> (2*d)) & (N - 1);
        int mx = 0;
        for (int i = 0; i < N; i++) if (exp_lvl[i] > mx) mx = exp_lvl[i];
        if (exp_lvl[p] == mx) step(1'b1, p, 1'b0, "R3 top push");
        else step(1'b1, p, 1'b0, "R2 push");
      end
      // R4: pulse gone after an idle cycle
      step(1'b0, 0, 1'b0, "R4 idle");
    end

    // R6: erase wins over a simultaneous push
    step(1'b1, 2, 1'b0, "R2 push");
    step(1'b1, 1, 1'b1, "R6 erase with push");

    // R4: repeated refused pushes keep the flag and the levels
    step(1'b1, 3, 1'b0, "R2 push");
    step(1'b1, 0, 1'b0, "R4 refused");
    step(1'b1, 1, 1'b0, "R4 refused again");
    step(1'b1, 3, 1'b0, "R3 top push at full");
    step(1'b0, 0, 1'b0, "R4 idle");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule